// File: doc/BRIEF.md
# Miscellaneous Register with Atomic Aliases

This block holds one 64-bit control/status word behind a simple word-oriented register bus. Software can read or overwrite the word at its plain offset, or update it in place through alias offsets that merge the write data into the current contents in a single access. Only the sixteen most significant bits are storage. Every other bit reads back as zero. The top stored bit is presented as a level-sensitive interrupt line.

The parameter `VARIANT` selects one of two address maps. Variant 0 places the plain word at word offset 0x4020 and offers bitwise-AND at 0x4021 and bitwise-OR at 0x4022. Variant 1 places the plain word at 0x6080 and offers bitwise-OR at 0x6082. In variant 1, offset 0x6081 empties the register whatever data is written. A bus byte address maps to a word offset by dropping its three low bits. Any access the block does not implement leaves the word untouched, reads as zero and raises a one-cycle flag.

Top module: `misc_alias_reg`

## Requirements
- R1: Every store, through any offset, keeps only bits 63..48 of the computed value; bits 47..0 of the register are always zero.
- R2: `irq_o` equals bit 63 of the stored word, and it changes on the same clock edge that stores a new value.
- R3: With `VARIANT`=0, a write to word 0x4020 stores the data, a write to 0x4021 stores (current AND data), and a write to 0x4022 stores (current OR data).
- R4: With `VARIANT`=1, a write to word 0x6080 stores the data, a write to 0x6081 stores zero regardless of data, and a write to 0x6082 stores (current OR data).
- R5: Every read request gets `rsp_valid` high one cycle later. `rsp_rdata` is the stored word for a read of the plain offset and zero for any other read.
- R6: The word offset is `req_addr` >> 3. An access is accepted only when `req_size` equals 8 and `req_addr[2:0]` is zero. Any other access is treated as unimplemented.
- R7: After reset the stored word is zero and `irq_o` is low.
- R8: An unimplemented access leaves the stored word unchanged and drives `unimpl_o` high for exactly the cycle after the request. Unimplemented accesses are reads or writes to an unknown offset, reads of an alias, and rejected sizes or alignments. `unimpl_o` is low in every other cycle.
- R9: `req_ready` is high at all times out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Always accepting |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | DATA_W | Read data |
| irq_o | output | 1 | Level interrupt, bit 63 of the stored word |
| unimpl_o | output | 1 | One-cycle flag for an unimplemented access |

## Verification
Every result is registered once. The stored word, `irq_o`, `rsp_valid`/`rsp_rdata` and `unimpl_o` all take the outcome of a request made before a rising edge, and that outcome is visible just after that edge. The bench drives each request at a falling edge and compares all outputs at the next falling edge against a reference model. It then drives the next request at that same falling edge, so each request's outcome is checked before the following request takes effect. Read data reflects the word as it stood before the edge. Both variants are instantiated side by side on the same bus, so each access is judged against both maps.

// File: rtl/misc_alias_pkg.sv
package misc_alias_pkg;

  typedef enum logic [2:0] {
    WR_NONE  = 3'd0,
    WR_LOAD  = 3'd1,
    WR_AND   = 3'd2,
    WR_OR    = 3'd3,
    WR_CLEAR = 3'd4
  } wr_op_e;

  typedef struct packed {
    wr_op_e wr_op;
    logic   rd_hit;
    logic   is_read;
    logic   unimpl;
  } decode_t;

endpackage

// File: rtl/misc_alias_rstsync.sv
module misc_alias_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/misc_alias_decode.sv
module misc_alias_decode
  import misc_alias_pkg::*;
#(
  parameter int VARIANT = 0,
  parameter int ADDR_W  = 24
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_size,
  output decode_t           dec
);
  localparam int WORD_W = ADDR_W - 3;
  localparam logic [WORD_W-1:0] OFF_BASE = (VARIANT == 0) ? WORD_W'(32'h4020) : WORD_W'(32'h6080);
  localparam logic [WORD_W-1:0] OFF_ALT1 = OFF_BASE + WORD_W'(1);
  localparam logic [WORD_W-1:0] OFF_ALT2 = OFF_BASE + WORD_W'(2);

  logic [WORD_W-1:0] word;
  logic              shape_ok;
  wr_op_e            alt1_op;

  assign word     = req_addr[ADDR_W-1:3];
  assign shape_ok = (req_size == 4'd8) && (req_addr[2:0] == 3'b000);

  generate
    if (VARIANT == 0) begin : g_var_and
      assign alt1_op = WR_AND;
    end else begin : g_var_clear
      assign alt1_op = WR_CLEAR;
    end
  endgenerate

  always_comb begin
    dec = '{wr_op: WR_NONE, rd_hit: 1'b0, is_read: 1'b0, unimpl: 1'b0};
    if (req_valid) begin
      dec.is_read = !req_write;
      if (!shape_ok) begin
        dec.unimpl = 1'b1;
      end else if (word == OFF_BASE) begin
        if (req_write) dec.wr_op  = WR_LOAD;
        else           dec.rd_hit = 1'b1;
      end else if (word == OFF_ALT1 && req_write) begin
        dec.wr_op = alt1_op;
      end else if (word == OFF_ALT2 && req_write) begin
        dec.wr_op = WR_OR;
      end else begin
        dec.unimpl = 1'b1;
      end
    end
  end
endmodule

// File: rtl/misc_alias_update.sv
module misc_alias_update
  import misc_alias_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int KEEP_W = 16
) (
  input  wr_op_e            wr_op,
  input  logic [DATA_W-1:0] cur,
  input  logic [DATA_W-1:0] wdata,
  output logic              store_en,
  output logic [DATA_W-1:0] store_val
);
  localparam logic [DATA_W-1:0] KEEP_MASK = ~({DATA_W{1'b1}} >> KEEP_W);

  logic [DATA_W-1:0] raw;

  always_comb begin
    store_en = 1'b1;
    unique case (wr_op)
      WR_LOAD:  raw = wdata;
      WR_AND:   raw = cur & wdata;
      WR_OR:    raw = cur | wdata;
      WR_CLEAR: raw = '0;
      default: begin
        raw      = cur;
        store_en = 1'b0;
      end
    endcase
    store_val = raw & KEEP_MASK;
  end
endmodule

// File: rtl/misc_alias_regs.sv
module misc_alias_regs
  import misc_alias_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_sync_n,
  input  decode_t           dec,
  input  logic              store_en,
  input  logic [DATA_W-1:0] store_val,
  output logic [DATA_W-1:0] value_q,
  output logic              irq_q,
  output logic              rsp_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              unimpl_q
);
  logic [DATA_W-1:0] rdata_d;
  logic              irq_d;

  always_comb begin
    rdata_d = dec.rd_hit ? value_q : '0;
    irq_d   = store_en ? store_val[DATA_W-1] : irq_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      value_q <= '0;
      irq_q   <= 1'b0;
    end else if (store_en) begin
      value_q <= store_val;
      irq_q   <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_q    <= 1'b0;
      rdata_q  <= '0;
      unimpl_q <= 1'b0;
    end else begin
      rsp_q    <= dec.is_read;
      rdata_q  <= rdata_d;
      unimpl_q <= dec.unimpl;
    end
  end
endmodule

// File: rtl/misc_alias_reg.sv
module misc_alias_reg
  import misc_alias_pkg::*;
#(
  parameter int VARIANT = 0,
  parameter int DATA_W  = 64,
  parameter int ADDR_W  = 24,
  parameter int KEEP_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              irq_o,
  output logic              unimpl_o
);
  logic              rst_sync_n;
  decode_t           dec;
  logic              store_en;
  logic [DATA_W-1:0] store_val;
  logic [DATA_W-1:0] stored_val;

  misc_alias_rstsync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  misc_alias_decode #(.VARIANT(VARIANT), .ADDR_W(ADDR_W)) u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .dec       (dec)
  );

  misc_alias_update #(.DATA_W(DATA_W), .KEEP_W(KEEP_W)) u_upd (
    .wr_op     (dec.wr_op),
    .cur       (stored_val),
    .wdata     (req_wdata),
    .store_en  (store_en),
    .store_val (store_val)
  );

  misc_alias_regs #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .dec        (dec),
    .store_en   (store_en),
    .store_val  (store_val),
    .value_q    (stored_val),
    .irq_q      (irq_o),
    .rsp_q      (rsp_valid),
    .rdata_q    (rsp_rdata),
    .unimpl_q   (unimpl_o)
  );

  assign req_ready = rst_sync_n;
endmodule

// File: rtl/misc_alias_chk.sv
module misc_alias_chk #(
  parameter int DATA_W = 64,
  parameter int KEEP_W = 16
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              req_valid,
  input logic              req_write,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              irq_o,
  input logic              unimpl_o,
  input logic [DATA_W-1:0] stored_val
);
  localparam int LOW_W = DATA_W - KEEP_W;

  // R1
  a_r1_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_valid |-> (rsp_rdata[LOW_W-1:0] == '0));

  // R2
  a_r2_irq_tracks_msb: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_o == stored_val[DATA_W-1]);

  // R5
  a_r5_read_answered: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && !req_write) |=> rsp_valid);

  // R5
  a_r5_rsp_has_cause: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_valid |-> $past(req_valid && !req_write));

  // R8
  a_r8_unimpl_no_change: assert property (@(posedge clk) disable iff (!rst_sync_n)
    unimpl_o |-> $stable(stored_val));

  // R8
  a_r8_unimpl_has_cause: assert property (@(posedge clk) disable iff (!rst_sync_n)
    unimpl_o |-> $past(req_valid));
endmodule

bind misc_alias_reg misc_alias_chk #(.DATA_W(DATA_W), .KEEP_W(KEEP_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .rsp_valid  (rsp_valid),
  .rsp_rdata  (rsp_rdata),
  .irq_o      (irq_o),
  .unimpl_o   (unimpl_o),
  .stored_val (stored_val)
);

// File: tb/misc_alias_reg_tb.sv
module misc_alias_reg_tb;
  localparam int DW = 64;
  localparam int AW = 24;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_write;
  logic [AW-1:0] req_addr;
  logic [3:0]    req_size;
  logic [DW-1:0] req_wdata;

  logic          rdy_a, rsp_a, irq_a, un_a;
  logic [DW-1:0] rd_a;
  logic          rdy_b, rsp_b, irq_b, un_b;
  logic [DW-1:0] rd_b;

  int n_vec;
  int n_bad;
  logic [DW-1:0] mdl [2];

  misc_alias_reg #(.VARIANT(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .req_ready(rdy_a), .rsp_valid(rsp_a), .rsp_rdata(rd_a),
    .irq_o(irq_a), .unimpl_o(un_a));

  misc_alias_reg #(.VARIANT(1)) u_dut_b (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .req_ready(rdy_b), .rsp_valid(rsp_b), .rsp_rdata(rd_b),
    .irq_o(irq_b), .unimpl_o(un_b));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference: offsets per variant (R3, R4); shape rule (R6)
  function automatic int op_of(input int v, input logic [AW-1:0] a, input logic [3:0] sz,
                               input logic wr);
    // 0 none/unimpl, 1 load, 2 and, 3 or, 4 clear, 5 plain read
    int base;
    int w;
    base = (v == 0) ? 32'h4020 : 32'h6080;
    w = int'(a >> 3);
    if (sz != 4'd8 || a[2:0] != 3'd0) return 0;
    if (w == base) return wr ? 1 : 5;
    if (wr && w == base + 1) return (v == 0) ? 2 : 4;
    if (wr && w == base + 2) return 3;
    return 0;
  endfunction

  function automatic logic [DW-1:0] keep(input logic [DW-1:0] x);
    return {x[63:48], 48'h0};
  endfunction

  task automatic access(input logic wr, input logic [AW-1:0] a, input logic [3:0] sz,
                        input logic [DW-1:0] d);
    int op [2];
    logic [DW-1:0] exp_rd [2];
    for (int v = 0; v < 2; v++) begin
      op[v] = op_of(v, a, sz, wr);
      exp_rd[v] = (op[v] == 5) ? mdl[v] : '0;
      case (op[v])
        1: mdl[v] = keep(d);
        2: mdl[v] = keep(mdl[v] & d);
        3: mdl[v] = keep(mdl[v] | d);
        4: mdl[v] = '0;
        default: ;
      endcase
    end
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R5 rsp_valid A", {63'd0, rsp_a}, {63'd0, !wr});
    chk("R5 rsp_valid B", {63'd0, rsp_b}, {63'd0, !wr});
    if (!wr) begin
      chk("R5/R1 rdata A", rd_a, exp_rd[0]);
      chk("R5/R1 rdata B", rd_b, exp_rd[1]);
    end
    chk("R2 irq A", {63'd0, irq_a}, {63'd0, mdl[0][63]});
    chk("R2 irq B", {63'd0, irq_b}, {63'd0, mdl[1][63]});
    chk("R8 unimpl A", {63'd0, un_a}, {63'd0, op[0] == 0});
    chk("R8 unimpl B", {63'd0, un_b}, {63'd0, op[1] == 0});
    chk("R9 ready", {62'd0, rdy_a, rdy_b}, 64'd3);
  endtask

  task automatic rd_plain(input int v);
    access(1'b0, (v == 0) ? 24'(32'h4020 << 3) : 24'(32'h6080 << 3), 4'd8, '0);
  endtask

  initial begin
    n_vec = 0; n_bad = 0;
    mdl[0] = '0; mdl[1] = '0;
    req_valid = 0; req_write = 0; req_addr = '0; req_size = 4'd8; req_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R7 reset state
    chk("R7 irq A", {63'd0, irq_a}, 64'd0);
    chk("R7 irq B", {63'd0, irq_b}, 64'd0);
    chk("R8 idle unimpl", {62'd0, un_a, un_b}, 64'd0);
    rd_plain(0);
    rd_plain(1);

    // R3 variant 0 directed
    access(1'b1, 24'(32'h4020 << 3), 4'd8, 64'hFFFF_FFFF_FFFF_FFFF);  // R1 masking
    rd_plain(0);
    access(1'b1, 24'(32'h4021 << 3), 4'd8, 64'h7FF0_FFFF_FFFF_FFFF);  // AND drops irq
    rd_plain(0);
    access(1'b1, 24'(32'h4022 << 3), 4'd8, 64'h8001_0000_0000_1234);  // OR raises irq
    rd_plain(0);
    access(1'b0, 24'(32'h4021 << 3), 4'd8, '0);  // R5 alias read zero
    // R6 shape rejects
    access(1'b1, 24'((32'h4020 << 3) + 4), 4'd8, '0);
    access(1'b1, 24'(32'h4020 << 3), 4'd4, '0);
    access(1'b0, 24'((32'h4020 << 3) + 1), 4'd8, '0);
    rd_plain(0);
    // R4 variant 1 directed
    access(1'b1, 24'(32'h6080 << 3), 4'd8, 64'h8123_4567_89AB_CDEF);
    rd_plain(1);
    access(1'b1, 24'(32'h6081 << 3), 4'd8, 64'hFFFF_FFFF_FFFF_FFFF);  // clear
    rd_plain(1);
    access(1'b1, 24'(32'h6082 << 3), 4'd8, 64'h8000_0000_0000_0000);
    access(1'b1, 24'(32'h6082 << 3), 4'd8, 64'h0042_0000_0000_0000);
    rd_plain(1);
    access(1'b1, 24'(32'h1234 << 3), 4'd8, 64'hFFFF_0000_0000_0000); // R8 unknown
    rd_plain(1);

    // Random mix
    void'($urandom(32'd2024));
    for (int i = 0; i < 600; i++) begin
      logic [AW-1:0] a;
      logic [3:0] sz;
      int pick;
      pick = int'($urandom % 9);
      case (pick)
        0: a = 24'(32'h4020 << 3);
        1: a = 24'(32'h4021 << 3);
        2: a = 24'(32'h4022 << 3);
        3: a = 24'(32'h6080 << 3);
        4: a = 24'(32'h6081 << 3);
        5: a = 24'(32'h6082 << 3);
        6: a = 24'(32'h4023 << 3);
        7: a = 24'(32'h607F << 3);
        default: a = 24'($urandom);
      endcase
      sz = ($urandom % 10 == 0) ? 4'($urandom) : 4'd8;
      if ($urandom % 12 == 0) a[2:0] = 3'($urandom);
      access(1'($urandom), a, sz, {$urandom, $urandom});
      if ($urandom % 5 == 0) @(negedge clk);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule